// File: doc/BRIEF.md
# Dual-Core Mailbox FIFO Pair

This block joins two processor cores that share one clock through two one-way word queues, one for each direction. Each core sees the writable end of the queue that carries its own words to its partner, and the readable end of the queue that carries the partner's words back. Neither core can touch the other ends. Each core has a small register-style access port with an address, read and write strobes, write data and read data. Read data is combinational, so it is valid in the same cycle as the read strobe.

Through the port a core can push a word into its transmit queue, pop a word from its receive queue, or read and write a status word. The status word shows whether data is waiting, whether the transmit queue has room, and two sticky error flags. Each core has an interrupt line that is high while received data is waiting or either error flag is set. Back-pressure is not enforced by a handshake. A core is expected to check the ready bit before writing and the valid bit before reading. If it does not, the access is harmlessly rejected and recorded in the sticky flags.

Top module: `mbox_pair`

## Requirements
- R1: After reset both queues are empty. Each core's status reads 0x2 (ready set, all other bits clear), and both interrupt lines are low.
- R2: Words written by core k are read by the other core in the order they were written. A word written in one cycle is valid to the reader from the next cycle on. Address map: 0 = transmit write, 1 = receive read, 2 = status.
- R3: Each queue holds 8 words of 32 bits. The ready bit (status bit 1) is clear while the transmit queue holds 8 words. A write to a full transmit queue with no pop in the same cycle discards the word and sets the overflow flag (status bit 2).
- R4: A read from an empty receive queue returns zero, leaves the queue unchanged and sets the underflow flag (status bit 3).
- R5: The overflow and underflow flags stay set until the core writes its status address with that flag's bit set. Such a write clears only the flags whose bits are 1.
- R6: Each core's interrupt equals its valid bit (status bit 0, receive queue not empty) OR its overflow flag OR its underflow flag.
- R7: A push and a pop on the same queue in one cycle are both honoured, even when the queue is full. In that case no overflow is flagged.
- R8: Traffic in one direction never alters the other direction's queue. A core only ever reads words that its partner wrote.
- R9: Status bits 31..4 read as zero. A read of address 0 or 3 returns zero. Writes to address 1 or 3 have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shared clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| c0_addr | input | 2 | Core 0 register address |
| c0_rd | input | 1 | Core 0 read strobe |
| c0_wr | input | 1 | Core 0 write strobe |
| c0_wdata | input | 32 | Core 0 write data |
| c0_rdata | output | 32 | Core 0 read data (combinational) |
| c0_irq | output | 1 | Core 0 interrupt |
| c1_addr | input | 2 | Core 1 register address |
| c1_rd | input | 1 | Core 1 read strobe |
| c1_wr | input | 1 | Core 1 write strobe |
| c1_wdata | input | 32 | Core 1 write data |
| c1_rdata | output | 32 | Core 1 read data (combinational) |
| c1_irq | output | 1 | Core 1 interrupt |

## Verification
The bench sweeps every fill level from zero to nine writes in each direction. It then drains one more word than was written. This tells exact capacity apart from off-by-one errors, separates ordered delivery from lost or duplicated words, and ends every run with an underflow read. Flags are cleared partly and then fully, which shows whether each clear bit acts only on its own flag. Cycles where one core writes while the other reads the full queue check the full-queue push-pop case against a real overflow. Cycles where both cores write at once check that the two directions stay separate.

// File: rtl/mbox_pkg.sv
package mbox_pkg;
  localparam int unsigned MB_WIDTH = 32;
  localparam int unsigned MB_DEPTH = 8;
  localparam int unsigned MB_AW    = 2;

  // register addresses
  localparam int unsigned ADR_TX   = 0;
  localparam int unsigned ADR_RX   = 1;
  localparam int unsigned ADR_STAT = 2;

  // status bit positions
  localparam int unsigned ST_VALID = 0;
  localparam int unsigned ST_READY = 1;
  localparam int unsigned ST_OVF   = 2;
  localparam int unsigned ST_UND   = 3;
endpackage

// File: rtl/mbox_fifo.sv
module mbox_fifo #(
  parameter int unsigned WIDTH = 32,
  parameter int unsigned DEPTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic [WIDTH-1:0] push_data,
  input  logic             pop,
  output logic [WIDTH-1:0] head,
  output logic             empty,
  output logic             full
);
  localparam int unsigned PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CW = $clog2(DEPTH + 1);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [PW-1:0]    wptr, rptr;
  logic [CW-1:0]    count;

  function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign empty = (count == '0);
  assign full  = (count == CW'(DEPTH));
  assign head  = mem[rptr];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr  <= '0;
      rptr  <= '0;
      count <= '0;
    end else begin
      if (push) wptr <= bump(wptr);
      if (pop)  rptr <= bump(rptr);
      case ({push, pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (push) mem[wptr] <= push_data;
  end

  // R3: a push is never accepted into a full queue unless a pop frees a slot
  a_r3_no_push_when_full: assert property (@(posedge clk) disable iff (!rst_n)
    (full && !pop) |-> !push);

  // R4: never pop an empty queue
  a_r4_no_pop_when_empty: assert property (@(posedge clk) disable iff (!rst_n)
    empty |-> !pop);

  // R2: a pushed word is visible one cycle later
  a_r2_push_visible: assert property (@(posedge clk) disable iff (!rst_n)
    (push && !pop) |=> !empty);

  // R7: push and pop together on a full queue keep it full
  a_r7_full_pushpop: assert property (@(posedge clk) disable iff (!rst_n)
    (full && push && pop) |=> full);
endmodule

// File: rtl/mbox_port.sv
module mbox_port
  import mbox_pkg::*;
#(
  parameter int unsigned WIDTH = 32,
  parameter int unsigned AW    = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [AW-1:0]    addr,
  input  logic             rd,
  input  logic             wr,
  input  logic [WIDTH-1:0] wdata,
  output logic [WIDTH-1:0] rdata,
  output logic             irq,
  // receive queue read end
  input  logic             rx_empty,
  input  logic [WIDTH-1:0] rx_head,
  output logic             rx_pop,
  // transmit queue write end
  input  logic             tx_full,
  input  logic             tx_room,
  output logic             tx_push
);
  logic ovf_q, und_q;
  logic tx_wr, rx_rd, st_wr;
  logic [WIDTH-1:0] status;

  assign tx_wr = wr && (addr == AW'(ADR_TX));
  assign rx_rd = rd && (addr == AW'(ADR_RX));
  assign st_wr = wr && (addr == AW'(ADR_STAT));

  assign tx_push = tx_wr && tx_room;
  assign rx_pop  = rx_rd && !rx_empty;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ovf_q <= 1'b0;
      und_q <= 1'b0;
    end else begin
      if (tx_wr && !tx_room)         ovf_q <= 1'b1;
      else if (st_wr && wdata[ST_OVF]) ovf_q <= 1'b0;
      if (rx_rd && rx_empty)         und_q <= 1'b1;
      else if (st_wr && wdata[ST_UND]) und_q <= 1'b0;
    end
  end

  always_comb begin
    status           = '0;
    status[ST_VALID] = !rx_empty;
    status[ST_READY] = !tx_full;
    status[ST_OVF]   = ovf_q;
    status[ST_UND]   = und_q;
  end

  always_comb begin
    rdata = '0;
    if (rd) begin
      if (addr == AW'(ADR_RX)) rdata = rx_empty ? '0 : rx_head;
      else if (addr == AW'(ADR_STAT)) rdata = status;
    end
  end

  assign irq = !rx_empty || ovf_q || und_q;

  // R3: a rejected write raises overflow
  a_r3_overflow_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_wr && !tx_room) |=> ovf_q);

  // R4: reading an empty queue raises underflow and yields zero
  a_r4_underflow_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_rd && rx_empty) |=> und_q);
  a_r4_empty_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_rd && rx_empty) |-> (rdata == '0));

  // R5: sticky flags only fall on an explicit clear
  a_r5_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_q && !(st_wr && wdata[ST_OVF])) |=> ovf_q);
  a_r5_und_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (und_q && !(st_wr && wdata[ST_UND])) |=> und_q);
endmodule

// File: rtl/mbox_pair.sv
module mbox_pair
  import mbox_pkg::*;
#(
  parameter int unsigned WIDTH = MB_WIDTH,
  parameter int unsigned DEPTH = MB_DEPTH,
  parameter int unsigned AW    = MB_AW
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [AW-1:0]    c0_addr,
  input  logic             c0_rd,
  input  logic             c0_wr,
  input  logic [WIDTH-1:0] c0_wdata,
  output logic [WIDTH-1:0] c0_rdata,
  output logic             c0_irq,
  input  logic [AW-1:0]    c1_addr,
  input  logic             c1_rd,
  input  logic             c1_wr,
  input  logic [WIDTH-1:0] c1_wdata,
  output logic [WIDTH-1:0] c1_rdata,
  output logic             c1_irq
);
  localparam int unsigned NCORE = 2;

  logic [NCORE-1:0][AW-1:0]    addr;
  logic [NCORE-1:0]            rd, wr, irq;
  logic [NCORE-1:0][WIDTH-1:0] wdata, rdata;

  // queue k carries words from core k to core 1-k
  logic [NCORE-1:0]            q_push, q_pop, q_empty, q_full, q_room;
  logic [NCORE-1:0][WIDTH-1:0] q_head;

  assign addr[0]  = c0_addr;   assign addr[1]  = c1_addr;
  assign rd[0]    = c0_rd;     assign rd[1]    = c1_rd;
  assign wr[0]    = c0_wr;     assign wr[1]    = c1_wr;
  assign wdata[0] = c0_wdata;  assign wdata[1] = c1_wdata;
  assign c0_rdata = rdata[0];  assign c1_rdata = rdata[1];
  assign c0_irq   = irq[0];    assign c1_irq   = irq[1];

  for (genvar k = 0; k < NCORE; k++) begin : g_lane
    localparam int unsigned PEER = NCORE - 1 - k;

    // a full queue still takes a word when its reader pops that cycle
    assign q_room[k] = !q_full[k] || q_pop[k];

    mbox_fifo #(.WIDTH(WIDTH), .DEPTH(DEPTH)) i_fifo (
      .clk       (clk),
      .rst_n     (rst_n),
      .push      (q_push[k]),
      .push_data (wdata[k]),
      .pop       (q_pop[k]),
      .head      (q_head[k]),
      .empty     (q_empty[k]),
      .full      (q_full[k])
    );

    mbox_port #(.WIDTH(WIDTH), .AW(AW)) i_port (
      .clk      (clk),
      .rst_n    (rst_n),
      .addr     (addr[k]),
      .rd       (rd[k]),
      .wr       (wr[k]),
      .wdata    (wdata[k]),
      .rdata    (rdata[k]),
      .irq      (irq[k]),
      .rx_empty (q_empty[PEER]),
      .rx_head  (q_head[PEER]),
      .rx_pop   (q_pop[PEER]),
      .tx_full  (q_full[k]),
      .tx_room  (q_room[k]),
      .tx_push  (q_push[k])
    );
  end

  // R8: each queue is pushed only by its own writer, so the two directions stay apart
  a_r8_push_source: assert property (@(posedge clk) disable iff (!rst_n)
    q_push[0] |-> (c0_wr && c0_addr == AW'(ADR_TX)));
  a_r8_push_source_b: assert property (@(posedge clk) disable iff (!rst_n)
    q_push[1] |-> (c1_wr && c1_addr == AW'(ADR_TX)));
endmodule

// File: tb/test_mbox_pair.sv
module test_mbox_pair;
  localparam int DEPTH = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [1:0]  c0_addr = '0, c1_addr = '0;
  logic        c0_rd = 0, c0_wr = 0, c1_rd = 0, c1_wr = 0;
  logic [31:0] c0_wdata = '0, c1_wdata = '0;
  logic [31:0] c0_rdata, c1_rdata;
  logic        c0_irq, c1_irq;

  int total = 0;
  int bad = 0;

  logic [31:0] mq0[$];
  logic [31:0] mq1[$];
  bit ovf[2];
  bit und[2];

  always #5 clk = ~clk;

  mbox_pair i_mbox_pair (
    .clk(clk), .rst_n(rst_n),
    .c0_addr(c0_addr), .c0_rd(c0_rd), .c0_wr(c0_wr), .c0_wdata(c0_wdata),
    .c0_rdata(c0_rdata), .c0_irq(c0_irq),
    .c1_addr(c1_addr), .c1_rd(c1_rd), .c1_wr(c1_wr), .c1_wdata(c1_wdata),
    .c1_rdata(c1_rdata), .c1_irq(c1_irq)
  );

  function automatic int qsize(input int k);
    return (k == 0) ? mq0.size() : mq1.size();
  endfunction

  function automatic logic [31:0] qhead(input int k);
    if (qsize(k) == 0) return '0;
    return (k == 0) ? mq0[0] : mq1[0];
  endfunction

  function automatic logic [31:0] stat(input int c);
    logic [31:0] s = '0;
    s[0] = qsize(1 - c) > 0;
    s[1] = qsize(c) < DEPTH;
    s[2] = ovf[c];
    s[3] = und[c];
    return s;
  endfunction

  task automatic check(input logic [31:0] got, input logic [31:0] exp, input string tag, input string what);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, got, exp);
    end
  endtask

  // one cycle with both ports driven; model updated from requirements
  task automatic step(input logic [1:0] a0, input bit r0, input bit w0, input logic [31:0] d0,
                      input logic [1:0] a1, input bit r1, input bit w1, input logic [31:0] d1,
                      input string tag);
    logic [1:0]  aa[2];
    bit          rr[2], ww[2], popd[2];
    logic [31:0] dd[2], ex[2], got[2];
    int          sz[2];
    aa[0] = a0; aa[1] = a1; rr[0] = r0; rr[1] = r1;
    ww[0] = w0; ww[1] = w1; dd[0] = d0; dd[1] = d1;
    for (int c = 0; c < 2; c++) begin
      sz[c] = qsize(c);
      ex[c] = '0;
      if (rr[c] && aa[c] == 2'd1) ex[c] = qhead(1 - c);
      if (rr[c] && aa[c] == 2'd2) ex[c] = stat(c);
    end
    @(negedge clk);
    c0_addr = a0; c0_rd = r0; c0_wr = w0; c0_wdata = d0;
    c1_addr = a1; c1_rd = r1; c1_wr = w1; c1_wdata = d1;
    #2;
    got[0] = c0_rdata; got[1] = c1_rdata;
    for (int c = 0; c < 2; c++)
      if (rr[c]) check(got[c], ex[c], tag, $sformatf("core%0d rdata addr=%0d", c, aa[c]));
    @(posedge clk);
    #1;
    c0_rd = 0; c0_wr = 0; c1_rd = 0; c1_wr = 0;
    for (int c = 0; c < 2; c++)
      popd[c] = rr[c] && aa[c] == 2'd1 && sz[1 - c] > 0;
    for (int c = 0; c < 2; c++) begin
      if (rr[c] && aa[c] == 2'd1) begin
        if (popd[c]) begin
          if (c == 0) void'(mq1.pop_front()); else void'(mq0.pop_front());
        end else und[c] = 1;
      end
    end
    for (int c = 0; c < 2; c++) begin
      if (ww[c] && aa[c] == 2'd0) begin
        if (sz[c] < DEPTH || popd[1 - c]) begin
          if (c == 0) mq0.push_back(dd[c]); else mq1.push_back(dd[c]);
        end else ovf[c] = 1;
      end
      if (ww[c] && aa[c] == 2'd2) begin
        if (dd[c][2]) ovf[c] = 0;
        if (dd[c][3]) und[c] = 0;
      end
    end
    check({31'b0, c0_irq}, {31'b0, (qsize(1) > 0) || ovf[0] || und[0]}, "R6", "core0 irq");
    check({31'b0, c1_irq}, {31'b0, (qsize(0) > 0) || ovf[1] || und[1]}, "R6", "core1 irq");
  endtask

  task automatic op(input int c, input logic [1:0] a, input bit r, input bit w,
                    input logic [31:0] d, input string tag);
    if (c == 0) step(a, r, w, d, 2'd0, 0, 0, '0, tag);
    else        step(2'd0, 0, 0, '0, a, r, w, d, tag);
  endtask

  function automatic logic [31:0] word(input int c, input int n, input int i);
    return 32'hA500_0000 ^ (c << 16) ^ (n << 8) ^ (i * 32'h0101_0101);
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL R1 watchdog actual=timeout expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    // R1: reset state
    check({31'b0, c0_irq}, 32'd0, "R1", "core0 irq after reset");
    check({31'b0, c1_irq}, 32'd0, "R1", "core1 irq after reset");
    op(0, 2'd2, 1, 0, '0, "R1");
    op(1, 2'd2, 1, 0, '0, "R1");

    // R2 R3 R4 R5: sweep fill levels in both directions
    for (int n = 0; n <= DEPTH + 1; n++) begin
      for (int c = 0; c < 2; c++) begin
        for (int i = 0; i < n; i++) op(c, 2'd0, 0, 1, word(c, n, i), "R3");
        op(c, 2'd2, 1, 0, '0, "R3");
        op(1 - c, 2'd2, 1, 0, '0, "R2");
        for (int i = 0; i <= n; i++) op(1 - c, 2'd1, 1, 0, '0, (i == n) ? "R4" : "R2");
        op(1 - c, 2'd2, 1, 0, '0, "R4");
        if (n == DEPTH + 1) begin
          op(c, 2'd2, 0, 1, 32'h0000_0008, "R5");
          op(c, 2'd2, 1, 0, '0, "R5");
          op(1 - c, 2'd2, 0, 1, 32'h0000_0004, "R5");
          op(1 - c, 2'd2, 1, 0, '0, "R5");
        end
        op(c, 2'd2, 0, 1, 32'h0000_000C, "R5");
        op(1 - c, 2'd2, 0, 1, 32'h0000_000C, "R5");
        op(c, 2'd2, 1, 0, '0, "R5");
        op(1 - c, 2'd2, 1, 0, '0, "R5");
      end
    end

    // R7: full queue, push and pop in the same cycle
    for (int i = 0; i < DEPTH; i++) op(0, 2'd0, 0, 1, word(0, 20, i), "R7");
    op(0, 2'd2, 1, 0, '0, "R7");
    step(2'd0, 0, 1, word(0, 21, 0), 2'd1, 1, 0, '0, "R7");
    op(0, 2'd2, 1, 0, '0, "R7");
    step(2'd0, 0, 1, word(0, 21, 1), 2'd1, 1, 0, '0, "R7");
    op(0, 2'd0, 0, 1, 32'hDEAD_BEEF, "R3");
    op(0, 2'd2, 1, 0, '0, "R3");

    // R8: both cores write at once, each reads only the partner's words
    for (int i = 0; i < 3; i++)
      step(2'd0, 0, 1, word(2, 30, i), 2'd0, 0, 1, word(3, 30, i), "R8");
    for (int i = 0; i < 3; i++) op(0, 2'd1, 1, 0, '0, "R8");
    op(0, 2'd2, 1, 0, '0, "R8");
    for (int i = 0; i < DEPTH + 1; i++) op(1, 2'd1, 1, 0, '0, "R8");

    // R9: unused addresses and write-ignored addresses
    op(0, 2'd3, 1, 0, '0, "R9");
    op(1, 2'd0, 1, 0, '0, "R9");
    op(0, 2'd3, 0, 1, 32'hFFFF_FFFF, "R9");
    op(0, 2'd1, 0, 1, 32'h1234_5678, "R9");
    op(1, 2'd2, 1, 0, '0, "R9");
    op(0, 2'd2, 1, 0, '0, "R9");
    op(0, 2'd2, 0, 1, 32'hFFFF_FFFF, "R5");
    op(1, 2'd2, 0, 1, 32'hFFFF_FFFF, "R5");
    op(0, 2'd2, 1, 0, '0, "R9");
    op(1, 2'd2, 1, 0, '0, "R9");

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule